// File: doc/BRIEF.md
# RF Transmit/Receive Control Sequencer

This block drives the power and switching controls of an RF front end as the radio moves from receive to transmit and back. It owns four registered control outputs: the receive-path enable, the power-amplifier enable, and a complementary pair for the antenna transmit/receive switch. It also produces a synthesizer enable from the power-state bits. A static base-power level and a synthesizer gate bit are inputs, and a level-sensitive transmit request starts and ends each burst.

The power state is the pair (base_en, rx_path_en). It is receive when both are 1, transmit when base_en is 1 and rx_path_en is 0, synthesizer-only when base_en is 0 and rx_path_en is 1, and powered down when both are 0. During normal operation base_en stays static and only rx_path_en toggles. All spacings are counted in clock cycles from parameters. The defaults of 4, 66, 44 and 132 cycles fit a 44 MHz clock: 0.1 µs, 1.5 µs, 1 µs and 3 µs. There is no streaming data path, so every pin is a plain control level with no handshake. A sequence that has started always runs to its end, and the request level is looked at again only afterwards. The parameters must satisfy 1 <= DLY_AMP_ON < DLY_SW_ON, DLY_SW_OFF >= 1 and DLY_RX_ON >= 1.

Top module: `rfseq_txrx_ctrl`

## Requirements
- R1: While reset is held, and after it is released with tx_req low, rx_path_en=1, amp_en=0, ant_tx=0 and ant_tx_n=1.
- R2: In receive, the first clock edge that samples tx_req=1 and base_en=1 drives rx_path_en to 0. That edge is the entry reference edge.
- R3: amp_en rises DLY_AMP_ON clock edges after the entry reference edge.
- R4: ant_tx rises DLY_SW_ON edges after the entry reference edge. ant_tx_n is always the complement of ant_tx and changes on the same edge.
- R5: In transmit, the first edge that samples tx_req=0 drops amp_en. ant_tx falls DLY_SW_OFF edges later, and rx_path_en returns to 1 DLY_RX_ON edges after ant_tx falls.
- R6: base_en is sampled only in receive, to allow entry. With base_en=0, tx_req=1 leaves rx_path_en at 1 and amp_en at 0. Changing base_en during transmit does not alter the sequence outputs.
- R7: A change of tx_req during a sequence is deferred. A drop during entry lets entry finish, with ant_tx rising, before the return starts. A rise during the return lets rx_path_en reach 1 for one cycle before a new entry starts.
- R8: synth_en equals synth_gate AND (base_en OR rx_path_en). With synth_gate=0 it is 0 whatever the other bits are.
- R9: amp_en and ant_tx are 1 only while rx_path_en is 0. amp_en falls no later than ant_tx on the return, and rx_path_en rises only when both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Level request: 1 asks for transmit, 0 for receive |
| base_en | input | 1 | Static base power level of the front end |
| synth_gate | input | 1 | Software gate for the synthesizer |
| rx_path_en | output | 1 | Receive-path enable; low in transmit |
| amp_en | output | 1 | Power-amplifier enable |
| ant_tx | output | 1 | Antenna switch, transmit side |
| ant_tx_n | output | 1 | Antenna switch, complement of ant_tx |
| synth_en | output | 1 | Synthesizer enable |

## Verification
Each register output is due a fixed number of cycles after the edge that samples a request change. With an input driven after the falling edge of cycle c, rx_path_en changes in cycle c+1, amp_en in cycle c+1+DLY_AMP_ON and ant_tx in cycle c+1+DLY_SW_ON. On the return, amp_en changes in cycle c+1, ant_tx in cycle c+1+DLY_SW_OFF and rx_path_en in cycle c+1+DLY_SW_OFF+DLY_RX_ON. The scoreboard queues, for each transition, the value expected in that exact cycle and the old value in the cycle before it, so an early or late edge of even one cycle is reported. synth_en is combinational and is checked one cycle after its inputs settle.

// File: rtl/rfseq_pkg.sv
package rfseq_pkg;
  typedef enum logic [2:0] {
    PH_RX    = 3'd0,
    PH_UP    = 3'd1,
    PH_TX    = 3'd2,
    PH_DN_SW = 3'd3,
    PH_DN_RX = 3'd4
  } seq_phase_e;
endpackage

// File: rtl/rfseq_timer.sv
module rfseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] elapsed
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              elapsed <= '0;
    else if (restart)        elapsed <= CW'(1);
    else if (elapsed != TOP) elapsed <= elapsed + CW'(1);
  end
endmodule

// File: rtl/rfseq_fsm.sv
module rfseq_fsm
  import rfseq_pkg::*;
#(
  parameter int CW         = 8,
  parameter int DLY_AMP_ON = 4,
  parameter int DLY_SW_ON  = 66,
  parameter int DLY_SW_OFF = 44,
  parameter int DLY_RX_ON  = 132
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_req,
  input  logic          base_en,
  input  logic [CW-1:0] elapsed,
  output logic          restart,
  output logic          rx_path_en,
  output logic          amp_en,
  output logic          ant_load,
  output logic          ant_val
);
  localparam logic [CW-1:0] T_AMP = CW'(DLY_AMP_ON);
  localparam logic [CW-1:0] T_SW  = CW'(DLY_SW_ON);
  localparam logic [CW-1:0] T_OFF = CW'(DLY_SW_OFF);
  localparam logic [CW-1:0] T_RX  = CW'(DLY_RX_ON);

  seq_phase_e ph_q, ph_n;
  logic rx_n, amp_n;

  always_comb begin
    ph_n     = ph_q;
    restart  = 1'b0;
    rx_n     = rx_path_en;
    amp_n    = amp_en;
    ant_load = 1'b0;
    ant_val  = 1'b0;
    unique case (ph_q)
      PH_RX: if (tx_req && base_en) begin
        ph_n    = PH_UP;
        restart = 1'b1;
        rx_n    = 1'b0;
      end
      PH_UP: begin
        if (elapsed == T_AMP) amp_n = 1'b1;
        if (elapsed == T_SW) begin
          ant_load = 1'b1;
          ant_val  = 1'b1;
          ph_n     = PH_TX;
        end
      end
      PH_TX: if (!tx_req) begin
        amp_n   = 1'b0;
        restart = 1'b1;
        ph_n    = PH_DN_SW;
      end
      PH_DN_SW: if (elapsed == T_OFF) begin
        ant_load = 1'b1;
        ant_val  = 1'b0;
        restart  = 1'b1;
        ph_n     = PH_DN_RX;
      end
      PH_DN_RX: if (elapsed == T_RX) begin
        rx_n = 1'b1;
        ph_n = PH_RX;
      end
      default: ph_n = PH_RX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_RX;
      rx_path_en <= 1'b1;
      amp_en     <= 1'b0;
    end else begin
      ph_q       <= ph_n;
      rx_path_en <= rx_n;
      amp_en     <= amp_n;
    end
  end

  // R9: the amplifier is only powered with the receive path off
  p_amp_only_in_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    amp_en |-> !rx_path_en);
  // R3: the counter never runs past the switch target during entry
  p_entry_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_UP) |-> (elapsed <= T_SW));
  // R7: the request level is not looked at while the return is in progress
  p_return_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DN_SW && elapsed != T_OFF) |=> (ph_q == PH_DN_SW));
endmodule

// File: rtl/rfseq_ant_drv.sv
module rfseq_ant_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic val,
  output logic ant_tx,
  output logic ant_tx_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ant_tx   <= 1'b0;
      ant_tx_n <= 1'b1;
    end else if (load) begin
      ant_tx   <= val;
      ant_tx_n <= !val;
    end
  end

  // R4: the two switch lines move together on one edge
  p_pair_moves_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ant_tx) |-> $fell(ant_tx_n));
endmodule

// File: rtl/rfseq_synth_gate.sv
module rfseq_synth_gate (
  input  logic synth_gate,
  input  logic base_en,
  input  logic rx_path_en,
  output logic synth_en
);
  logic any_power;
  assign any_power = base_en | rx_path_en;
  assign synth_en  = synth_gate & any_power;
endmodule

// File: rtl/rfseq_txrx_ctrl.sv
module rfseq_txrx_ctrl #(
  parameter int DLY_AMP_ON = 4,
  parameter int DLY_SW_ON  = 66,
  parameter int DLY_SW_OFF = 44,
  parameter int DLY_RX_ON  = 132
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic base_en,
  input  logic synth_gate,
  output logic rx_path_en,
  output logic amp_en,
  output logic ant_tx,
  output logic ant_tx_n,
  output logic synth_en
);
  localparam int MAX_A = (DLY_SW_ON > DLY_SW_OFF) ? DLY_SW_ON : DLY_SW_OFF;
  localparam int MAXD  = (MAX_A > DLY_RX_ON) ? MAX_A : DLY_RX_ON;
  localparam int CW    = $clog2(MAXD + 2);

  logic          restart, ant_load, ant_val;
  logic [CW-1:0] elapsed;

  rfseq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .elapsed(elapsed)
  );

  rfseq_fsm #(
    .CW(CW), .DLY_AMP_ON(DLY_AMP_ON), .DLY_SW_ON(DLY_SW_ON),
    .DLY_SW_OFF(DLY_SW_OFF), .DLY_RX_ON(DLY_RX_ON)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .base_en(base_en),
    .elapsed(elapsed), .restart(restart), .rx_path_en(rx_path_en),
    .amp_en(amp_en), .ant_load(ant_load), .ant_val(ant_val)
  );

  rfseq_ant_drv u_ant (
    .clk(clk), .rst_n(rst_n), .load(ant_load), .val(ant_val),
    .ant_tx(ant_tx), .ant_tx_n(ant_tx_n)
  );

  rfseq_synth_gate u_syn (
    .synth_gate(synth_gate), .base_en(base_en),
    .rx_path_en(rx_path_en), .synth_en(synth_en)
  );

  // R9: the antenna is on the transmit side only with the receive path off
  p_ant_only_in_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ant_tx |-> !rx_path_en);
  // R5: the switch leaves transmit only after the amplifier is off
  p_amp_before_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ant_tx) |-> (!amp_en && $past(!amp_en)));
  // R5: receive resumes only with the amplifier and switch released
  p_rx_resume_safe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_path_en) |-> (!amp_en && !ant_tx));
  // R2: leaving receive needs a sampled request with base power present
  p_entry_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_path_en) |-> ($past(tx_req) && $past(base_en)));
endmodule

// File: tb/tb_rfseq_txrx_ctrl.sv
`timescale 1ns/1ps
module tb_rfseq_txrx_ctrl;
  localparam int DA  = 4;
  localparam int DS  = 66;
  localparam int DSO = 44;
  localparam int DRX = 132;

  localparam int S_RX = 0, S_AMP = 1, S_ANT = 2, S_ANTN = 3, S_SYN = 4;

  typedef struct {
    int    cyc;
    int    sig;
    bit    val;
    string req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_req = 1'b0, base_en = 1'b1, synth_gate = 1'b1;
  logic rx_path_en, amp_en, ant_tx, ant_tx_n, synth_en;

  int   cyc = 0;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rfseq_txrx_ctrl #(
    .DLY_AMP_ON(DA), .DLY_SW_ON(DS), .DLY_SW_OFF(DSO), .DLY_RX_ON(DRX)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .base_en(base_en),
    .synth_gate(synth_gate), .rx_path_en(rx_path_en), .amp_en(amp_en),
    .ant_tx(ant_tx), .ant_tx_n(ant_tx_n), .synth_en(synth_en)
  );

  task automatic expect_at(int c, int s, bit v, string r);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = r;
    sb.push_back(e);
  endtask

  function automatic bit pick(int s);
    case (s)
      S_RX:    return rx_path_en;
      S_AMP:   return amp_en;
      S_ANT:   return ant_tx;
      S_ANTN:  return ant_tx_n;
      default: return synth_en;
    endcase
  endfunction

  // monitor: pops every item due in this cycle and compares it
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        n_chk++;
        if (pick(sb[i].sig) !== sb[i].val) begin
          n_bad++;
          $display("FAIL %s cycle %0d signal %0d actual=%0b expected=%0b",
                   sb[i].req, cyc, sb[i].sig, pick(sb[i].sig), sb[i].val);
        end
        sb.delete(i);
      end
    end
    if (cyc > 7) begin
      n_chk++;
      if ((amp_en || ant_tx) && rx_path_en) begin
        n_bad++;
        $display("FAIL R9 cycle %0d actual rx=%0b amp=%0b ant=%0b expected rx=0",
                 cyc, rx_path_en, amp_en, ant_tx);
      end
      n_chk++;
      if (ant_tx_n !== !ant_tx) begin
        n_bad++;
        $display("FAIL R4 cycle %0d actual ant_tx_n=%0b expected=%0b",
                 cyc, ant_tx_n, !ant_tx);
      end
    end
  end

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // R2 R3 R4: entry timing from the falling edge of cycle c
  task automatic push_entry(int c);
    expect_at(c + 1, S_RX, 1'b0, "R2");
    expect_at(c + DA, S_AMP, 1'b0, "R3");
    expect_at(c + 1 + DA, S_AMP, 1'b1, "R3");
    expect_at(c + DS, S_ANT, 1'b0, "R4");
    expect_at(c + 1 + DS, S_ANT, 1'b1, "R4");
    expect_at(c + DS, S_ANTN, 1'b1, "R4");
    expect_at(c + 1 + DS, S_ANTN, 1'b0, "R4");
  endtask

  // R5: return timing from the falling edge of cycle c
  task automatic push_return(int c);
    expect_at(c + 1, S_AMP, 1'b0, "R5");
    expect_at(c + DSO, S_ANT, 1'b1, "R5");
    expect_at(c + 1 + DSO, S_ANT, 1'b0, "R5");
    expect_at(c + 1 + DSO, S_ANTN, 1'b1, "R5");
    expect_at(c + DSO + DRX, S_RX, 1'b0, "R5");
    expect_at(c + 1 + DSO + DRX, S_RX, 1'b1, "R5");
  endtask

  initial begin
    int c, c2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    c = cyc;
    expect_at(c + 1, S_RX, 1'b1, "R1");
    expect_at(c + 1, S_AMP, 1'b0, "R1");
    expect_at(c + 1, S_ANT, 1'b0, "R1");
    expect_at(c + 1, S_ANTN, 1'b1, "R1");
    expect_at(c + 1, S_SYN, 1'b1, "R8");
    repeat (3) @(negedge clk);

    // normal entry
    c = cyc; tx_req = 1'b1; push_entry(c);
    wait_until(c + DS + 3);

    // R8 and R6 while transmitting
    c = cyc; expect_at(c + 1, S_SYN, 1'b1, "R8");
    repeat (2) @(negedge clk);
    base_en = 1'b0; c = cyc;
    expect_at(c + 1, S_SYN, 1'b0, "R8");
    expect_at(c + 2, S_RX, 1'b0, "R6");
    expect_at(c + 2, S_AMP, 1'b1, "R6");
    expect_at(c + 2, S_ANT, 1'b1, "R6");
    repeat (3) @(negedge clk);
    base_en = 1'b1; synth_gate = 1'b0; c = cyc;
    expect_at(c + 1, S_SYN, 1'b0, "R8");
    repeat (2) @(negedge clk);
    synth_gate = 1'b1;
    repeat (2) @(negedge clk);

    // normal return
    c = cyc; tx_req = 1'b0; push_return(c);
    wait_until(c + DSO + DRX + 3);

    // R8 in receive
    synth_gate = 1'b0; c = cyc;
    expect_at(c + 1, S_SYN, 1'b0, "R8");
    repeat (2) @(negedge clk);
    synth_gate = 1'b1; base_en = 1'b0; c = cyc;
    expect_at(c + 1, S_SYN, 1'b1, "R8");
    repeat (2) @(negedge clk);

    // R6: request ignored without base power
    tx_req = 1'b1; c = cyc;
    for (int k = 1; k <= 20; k++) begin
      expect_at(c + k, S_RX, 1'b1, "R6");
      expect_at(c + k, S_AMP, 1'b0, "R6");
    end
    wait_until(c + 21);
    tx_req = 1'b0; base_en = 1'b1;
    repeat (3) @(negedge clk);

    // R7: request dropped during entry
    c = cyc; tx_req = 1'b1; push_entry(c);
    repeat (10) @(negedge clk);
    tx_req = 1'b0;
    expect_at(c + DS + 1, S_AMP, 1'b1, "R7");
    expect_at(c + DS + 2, S_AMP, 1'b0, "R7");
    expect_at(c + DS + 1 + DSO, S_ANT, 1'b1, "R7");
    expect_at(c + DS + 2 + DSO, S_ANT, 1'b0, "R7");
    expect_at(c + DS + 1 + DSO + DRX, S_RX, 1'b0, "R7");
    expect_at(c + DS + 2 + DSO + DRX, S_RX, 1'b1, "R7");
    wait_until(c + DS + DSO + DRX + 5);

    // R7: request raised during return
    c = cyc; tx_req = 1'b1; push_entry(c);
    wait_until(c + DS + 3);
    c2 = cyc; tx_req = 1'b0;
    expect_at(c2 + 1, S_AMP, 1'b0, "R7");
    repeat (20) @(negedge clk);
    tx_req = 1'b1;
    expect_at(c2 + 1 + DSO, S_ANT, 1'b0, "R7");
    expect_at(c2 + 1 + DSO + DRX, S_RX, 1'b1, "R7");
    expect_at(c2 + 2 + DSO + DRX, S_RX, 1'b0, "R7");
    expect_at(c2 + 1 + DSO + DRX + DA, S_AMP, 1'b0, "R7");
    expect_at(c2 + 2 + DSO + DRX + DA, S_AMP, 1'b1, "R7");
    expect_at(c2 + 2 + DSO + DRX + DS, S_ANT, 1'b1, "R7");
    wait_until(c2 + DSO + DRX + DS + 4);
    c = cyc; tx_req = 1'b0; push_return(c);
    wait_until(c + DSO + DRX + 4);

    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R1 scoreboard actual=%0d pending expected=0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule